// File: doc/BRIEF.md
# Sensor Row Zero-Bias Preprocessor

This block captures one image frame from an external image sensor, a row at a time, and removes the dark-level offset from each row before the host sees it. Every row reaches the block as a stream of byte samples qualified by a pixel-valid strobe. The block stores the active pixels of the row in an internal frame buffer and takes a bias from two fixed reference columns of that row. It then walks the stored row again and replaces each active pixel with the pixel minus the bias, clamped at zero.

The host starts a frame by writing to a control address on a small memory-mapped bus. It polls a busy bit at that same address and, once the frame is done, reads the corrected pixels back one byte per read. An output tells the sensor side when the block is ready to accept samples for the current row.

Top module: `sensor_zero_bias`

## Requirements
- R1: After reset, `busy_o`, `cap_open_o` and `rdata_o` are all 0.
- R2: A host write (`wr_i`) to the control address 4096 starts a frame when the block is idle. The data value does not matter. On the next cycle `busy_o` and `cap_open_o` are both 1, and capture begins at row 0, column 0.
- R3: While `cap_open_o` is 1, a sample is accepted only on a cycle where `pix_valid_i` is 1. Each row takes 66 accepted samples. Samples 0..63 are stored as active columns 0..63. Samples 64 and 65 are masked pixels: they are consumed but never become readable.
- R4: The bias of a row is floor((raw column 10 + raw column 11) / 2), computed over 9 bits from the raw samples of that row.
- R5: Each stored active pixel becomes max(raw − bias, 0).
- R6: `cap_open_o` falls on the cycle after a row's 66th sample is accepted. For rows 0..62 it rises again exactly 66 cycles after that sample's clock edge. After row 63, `busy_o` falls exactly 66 cycles after that edge and `cap_open_o` stays 0.
- R7: A read (`rd_i`) presents its result on `rdata_o` in the cycle after the request, and `rdata_o` holds it until the next read. Address row*64+col returns the corrected pixel. Address 4096 returns `busy_o` in bit 0 with the other bits 0. Any other address returns 0.
- R8: A control write while `busy_o` is 1 is ignored. A write to a buffer address (below 4096) does not change the buffer.
- R9: A new start after a frame completes captures again from row 0 and overwrites the whole buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Sensor sample |
| pix_valid_i | input | 1 | Qualifies `pix_i` this cycle |
| cap_open_o | output | 1 | Block is accepting samples for the current row |
| addr_i | input | 13 | Host address |
| wr_i | input | 1 | Host write strobe, one cycle |
| rd_i | input | 1 | Host read strobe, one cycle |
| rdata_o | output | 8 | Host read data, valid the cycle after `rd_i` |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench sweeps every pixel of three full frames. The patterns are chosen so that the bias lands on an odd sum, where a rounding-up divider is off by one. They also make it reach 255, where a divider that loses the ninth sum bit yields a small bias. In places the bias exceeds most pixels, so a wrapping subtractor shows large values where zeros belong. Idle cycles with garbage data sit inside each row. A design that accepts samples without the valid strobe, or that stores the masked samples into the active area, shifts every later pixel. The bench counts the exact number of cycles the window stays closed between rows, so an extra or missing processing state shows up. It also issues control writes during a frame and a write into the buffer, which expose a design that restarts or corrupts stored data.

// File: rtl/zb_pkg.sv
package zb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET,
    ST_BIAS,
    ST_FIX,
    ST_NEXT
  } zb_state_e;
endpackage

// File: rtl/zb_seq.sv
module zb_seq
  import zb_pkg::*;
#(
  parameter int ROWS       = 64,
  parameter int ACT_COLS   = 64,
  parameter int TOTAL_COLS = 66,
  parameter int RW         = 6,
  parameter int CW         = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          pix_valid_i,
  output zb_state_e     state_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o
);
  zb_state_e     state_q, state_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    col_d   = col_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_GET;
        row_d   = '0;
        col_d   = '0;
      end
      ST_GET: if (pix_valid_i) begin
        if (col_q == CW'(TOTAL_COLS - 1)) begin
          state_d = ST_BIAS;
          col_d   = '0;
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      ST_BIAS: state_d = ST_FIX;
      ST_FIX: begin
        if (col_q == CW'(ACT_COLS - 1)) begin
          state_d = ST_NEXT;
          col_d   = '0;
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      ST_NEXT: begin
        col_d = '0;
        if (row_q == RW'(ROWS - 1)) begin
          state_d = ST_IDLE;
          row_d   = '0;
        end else begin
          state_d = ST_GET;
          row_d   = row_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
    end
  end

  assign state_o = state_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
endmodule

// File: rtl/zb_bias.sv
module zb_bias #(
  parameter int PIX_W      = 8,
  parameter int CW         = 7,
  parameter int BIAS_COL_A = 10,
  parameter int BIAS_COL_B = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic [CW-1:0]    col_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             calc_i,
  input  logic [PIX_W-1:0] raw_i,
  output logic [PIX_W-1:0] fixed_o
);
  logic [PIX_W-1:0] ref_a_q, ref_b_q, bias_q;
  logic [PIX_W:0]   ref_sum;

  // reference samples are latched as they stream in, before the fix pass rewrites them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_a_q <= '0;
      ref_b_q <= '0;
    end else if (cap_en_i) begin
      if (col_i == CW'(BIAS_COL_A)) ref_a_q <= pix_i;
      if (col_i == CW'(BIAS_COL_B)) ref_b_q <= pix_i;
    end
  end

  assign ref_sum = {1'b0, ref_a_q} + {1'b0, ref_b_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bias_q <= '0;
    else if (calc_i) bias_q <= ref_sum[PIX_W:1];
  end

  assign fixed_o = (raw_i > bias_q) ? (raw_i - bias_q) : '0;
endmodule

// File: rtl/zb_pixbuf.sv
module zb_pixbuf #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 4096,
  parameter int AW    = 12
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [PIX_W-1:0] wdata_i,
  input  logic [AW-1:0]    ra_addr_i,
  output logic [PIX_W-1:0] ra_data_o,
  input  logic [AW-1:0]    rb_addr_i,
  output logic [PIX_W-1:0] rb_data_o
);
  logic [PIX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];
endmodule

// File: rtl/zb_host.sv
module zb_host #(
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 4096,
  parameter int AW     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic [AW-1:0]     buf_addr_o,
  input  logic [PIX_W-1:0]  buf_data_i,
  output logic [PIX_W-1:0]  rdata_o
);
  logic             hit_ctrl, hit_buf;
  logic [PIX_W-1:0] rdata_q;

  assign hit_ctrl   = (addr_i == ADDR_W'(DEPTH));
  assign hit_buf    = (addr_i < ADDR_W'(DEPTH));
  assign start_o    = wr_i && hit_ctrl && !busy_i;
  assign buf_addr_o = addr_i[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      if (hit_ctrl)     rdata_q <= {{(PIX_W-1){1'b0}}, busy_i};
      else if (hit_buf) rdata_q <= buf_data_i;
      else              rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sensor_zero_bias.sv
module sensor_zero_bias
  import zb_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int ROWS       = 64,
  parameter int ACT_COLS   = 64,
  parameter int MASK_COLS  = 2,
  parameter int BIAS_COL_A = 10,
  parameter int BIAS_COL_B = 11,
  parameter int ADDR_W     = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              pix_valid_i,
  output logic              cap_open_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [PIX_W-1:0]  rdata_o,
  output logic              busy_o
);
  localparam int TOTAL_COLS = ACT_COLS + MASK_COLS;
  localparam int DEPTH      = ROWS * ACT_COLS;
  localparam int AW         = $clog2(DEPTH);
  localparam int RW         = $clog2(ROWS);
  localparam int CW         = $clog2(TOTAL_COLS);

  zb_state_e        state;
  logic [RW-1:0]    row;
  logic [CW-1:0]    col;
  logic             start, sample_acc, buf_we;
  logic [AW-1:0]    seq_addr, host_addr;
  logic [PIX_W-1:0] buf_wdata, raw_pix, fixed_pix, host_pix;

  zb_seq #(
    .ROWS(ROWS), .ACT_COLS(ACT_COLS), .TOTAL_COLS(TOTAL_COLS), .RW(RW), .CW(CW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .pix_valid_i(pix_valid_i),
    .state_o    (state),
    .row_o      (row),
    .col_o      (col)
  );

  assign sample_acc = (state == ST_GET) && pix_valid_i;
  assign seq_addr   = AW'(row) * AW'(ACT_COLS) + AW'(col);
  // masked samples advance the column count but are never written
  assign buf_we     = (sample_acc && (col < CW'(ACT_COLS))) || (state == ST_FIX);
  assign buf_wdata  = (state == ST_FIX) ? fixed_pix : pix_i;

  zb_bias #(
    .PIX_W(PIX_W), .CW(CW), .BIAS_COL_A(BIAS_COL_A), .BIAS_COL_B(BIAS_COL_B)
  ) u_bias (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_en_i(sample_acc),
    .col_i   (col),
    .pix_i   (pix_i),
    .calc_i  (state == ST_BIAS),
    .raw_i   (raw_pix),
    .fixed_o (fixed_pix)
  );

  zb_pixbuf #(.PIX_W(PIX_W), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk_i    (clk_i),
    .we_i     (buf_we),
    .waddr_i  (seq_addr),
    .wdata_i  (buf_wdata),
    .ra_addr_i(seq_addr),
    .ra_data_o(raw_pix),
    .rb_addr_i(host_addr),
    .rb_data_o(host_pix)
  );

  zb_host #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .AW(AW)) u_host (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .busy_i    (busy_o),
    .start_o   (start),
    .buf_addr_o(host_addr),
    .buf_data_i(host_pix),
    .rdata_o   (rdata_o)
  );

  assign busy_o     = (state != ST_IDLE);
  assign cap_open_o = (state == ST_GET);
endmodule

// File: rtl/zb_checker.sv
module zb_checker #(
  parameter int PIX_W     = 8,
  parameter int ADDR_W    = 13,
  parameter int CTRL_ADDR = 4096
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pix_valid_i,
  input logic              cap_open_o,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [PIX_W-1:0]  rdata_o,
  input logic              busy_o
);
  logic ctrl_hit;
  assign ctrl_hit = (addr_i == ADDR_W'(CTRL_ADDR));

  assert_start_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wr_i && ctrl_hit) |=> (busy_o && cap_open_o));

  assert_hold_without_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_open_o && !pix_valid_i) |=> cap_open_o);

  assert_window_inside_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_open_o |-> busy_o);

  assert_status_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ctrl_hit) |=> (rdata_o == {{(PIX_W-1){1'b0}}, $past(busy_o)}));

  assert_unmapped_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i > ADDR_W'(CTRL_ADDR))) |=> (rdata_o == '0));

  assert_busy_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_open_o && wr_i) |=> busy_o);
endmodule

bind sensor_zero_bias zb_checker #(
  .PIX_W(PIX_W), .ADDR_W(ADDR_W), .CTRL_ADDR(ROWS * ACT_COLS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_valid_i(pix_valid_i),
  .cap_open_o (cap_open_o),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .busy_o     (busy_o)
);

// File: tb/sim_sensor_zero_bias.sv
module sim_sensor_zero_bias;
  localparam int ROWS = 64;
  localparam int COLS = 64;
  localparam int CTRL = 4096;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pix_i = '0;
  logic        pix_valid_i = 1'b0;
  logic        cap_open_o;
  logic [12:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        busy_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  sensor_zero_bias u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix_i), .pix_valid_i(pix_valid_i),
    .cap_open_o(cap_open_o), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int raw(input int f, input int r, input int c);
    if (c == 64) return 'hA5;
    if (c == 65) return 'h5A;
    case (f)
      0: return (r * 7 + c * 13 + 5) % 256;
      1: return (c == 10 || c == 11) ? 255 : (r * 3 + c * 11) % 256;
      default: begin
        if (c == 10) return r;
        if (c == 11) return r + 1;
        return (c * r) % 256;
      end
    endcase
  endfunction

  function automatic int expv(input int f, input int r, input int c);
    int b, d;
    b = (raw(f, r, 10) + raw(f, r, 11)) / 2;
    d = raw(f, r, c) - b;
    return (d < 0) ? 0 : d;
  endfunction

  task automatic host_rd(input int a, output int d);
    @(negedge clk_i);
    addr_i = 13'(a);
    rd_i   = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_i = 1'b0;
    d    = int'(rdata_o);
  endtask

  task automatic host_wr(input int a);
    @(negedge clk_i);
    addr_i = 13'(a);
    wr_i   = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic run_frame(input int f);
    int d;
    host_wr(CTRL);
    check("R2 busy after start", int'(busy_o), 1);
    check("R2 window after start", int'(cap_open_o), 1);
    for (int r = 0; r < ROWS; r++) begin
      int cnt;
      while (!cap_open_o) @(negedge clk_i);
      if (f == 1 && r == 5) begin
        host_rd(CTRL, d);
        check("R7 status busy", d, 1);
        host_wr(CTRL);   // R8: must be ignored mid-frame
      end
      for (int c = 0; c < 66; c++) begin
        if ((c + r + f) % 5 == 0) begin
          pix_i       = 8'hFF ^ 8'(c);   // R3: garbage with valid low
          pix_valid_i = 1'b0;
          @(posedge clk_i);
          @(negedge clk_i);
        end
        pix_i       = 8'(raw(f, r, c));
        pix_valid_i = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
      end
      pix_valid_i = 1'b0;
      pix_i       = 8'h3C;
      cnt = 0;
      while ((r < ROWS - 1) ? !cap_open_o : busy_o) begin
        @(posedge clk_i);
        @(negedge clk_i);
        cnt++;
        if (cnt > 200) break;
      end
      if (r == 0 || r == ROWS - 1) check("R6 row turnaround", cnt, 66);
    end
    check("R6 window closed at end", int'(cap_open_o), 0);
  endtask

  task automatic readback(input int f);
    int d;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        host_rd(r * COLS + c, d);
        // R4 R5 R3 R9: corrected value at row*64+col
        check("R5 pixel", d, expv(f, r, c));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk_i);
    check("R1 busy reset", int'(busy_o), 0);
    check("R1 window reset", int'(cap_open_o), 0);
    check("R1 rdata reset", int'(rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    host_rd(CTRL, d);
    check("R7 status idle", d, 0);
    host_rd(5000, d);
    check("R7 unmapped", d, 0);

    run_frame(0);
    readback(0);
    host_wr(5);
    host_rd(5, d);
    check("R8 buffer write ignored", d, expv(0, 0, 5));
    check("R8 no start from buffer write", int'(busy_o), 0);

    run_frame(1);
    repeat (5) @(negedge clk_i);
    check("R8 busy write did not restart", int'(busy_o), 0);
    readback(1);

    run_frame(2);
    readback(2);
    host_rd(CTRL, d);
    check("R7 status after frame", d, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule